// File: doc/BRIEF.md
# Slowdown-Bound Bandwidth Allocation Controller

This block divides the memory bandwidth of a shared memory controller among several applications, each running on its own core. Once per measurement interval an external estimator presents one slowdown figure per application together with a single-cycle strobe. The controller turns those figures into bandwidth shares. A share is an 8-bit count of scheduling slots out of 256. The downstream scheduler reads the shares directly from the packed allocation output.

There are two operating modes. In QoS mode a single critical application, chosen by an index input, is steered toward a slowdown bound. Its share is reviewed once every few intervals. It grows when the application is slowed too much and shrinks when the application has margin. The other applications divide the rest of the bandwidth. In fairness mode every interval moves a small amount of bandwidth from applications within the bound to applications outside it. In this mode the bound itself follows the recent history: it is tightened after a run of intervals in which every application met it, and relaxed after a run of intervals in which most applications missed it. In both modes a notify flag tells the operating system that misses have persisted.

Sequencing uses three states. ST_IDLE waits for the strobe and captures the estimates; it moves to ST_EVAL when the strobe is high. ST_EVAL updates the run counters and the review counter, then always moves to ST_APPLY. ST_APPLY writes the shares, the bound and the notify flag, then always returns to ST_IDLE. The outputs therefore change on the second rising edge after the edge that accepted the strobe.

Top module: `sdb_bw_alloc`

## Requirements
- R1: After reset, application 0 holds INIT_SHARE (64) and the other applications split the remainder evenly, giving 64 each. The bound equals BOUND_INIT (48, unsigned fixed point with 4 fraction bits, so 16 means 1.0). Notify is low.
- R2: In QoS mode the critical share is reviewed only on every 4th accepted interval, counted from reset. At a review, if the critical slowdown is greater than bound+EPS (EPS=2), the share rises by STEP (8).
- R3: At a QoS review, if the critical slowdown plus EPS is less than the bound, the share falls by STEP. A slowdown inside the band leaves the share unchanged.
- R4: After a QoS review the non-critical applications share 256 minus the critical share evenly. Any remainder from the division goes to the lowest-index non-critical application.
- R5: The critical share is clamped to the range [1, 256-(NAPP-1)] = [1, 253].
- R6: Notify rises once 4 consecutive intervals have each had a miss, and it drops after the first interval without one. A miss means slowdown greater than bound. In QoS mode the interval counts if the critical application missed; in fairness mode it counts if more than half of the applications missed.
- R7: In fairness mode, every interval in which at least one application meets the bound and at least one misses it triggers a transfer. Each meeting application gives up min(STEP, share-1). The pool is split evenly among the missing applications, and the remainder goes to the lowest-index missing one.
- R8: No fairness share drops below 1. If every application misses, or every application meets the bound, the shares are left unchanged.
- R9: In fairness mode, after 4 consecutive intervals in which every application met the bound, the bound becomes the largest slowdown of the current interval plus 1, and the run count restarts.
- R10: In fairness mode, after 4 consecutive intervals in which more than half of the applications missed, the bound becomes the largest current slowdown, and the run count restarts.
- R11: A strobe that arrives while an interval is being processed is ignored. The bound never changes in QoS mode.
- R12: The shares always sum to 256, and every share is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fair_mode | input | 1 | 1 selects fairness mode, 0 selects QoS mode |
| crit_sel | input | 2 | Index of the critical application in QoS mode |
| sd_valid | input | 1 | One-cycle strobe marking a new set of estimates |
| sd_vec | input | 48 | Slowdown of application i in bits [12i+11:12i], 4 fraction bits |
| share_vec | output | 32 | Share of application i in bits [8i+7:8i], in units of 1/256 |
| bound | output | 12 | Current slowdown bound, same format as the estimates |
| notify | output | 1 | Persistent-miss flag for the operating system |

## Verification
A wrong run or review counter does not show up at once. It first appears as a share or bound update that comes one or more intervals too early or too late, so each check is made after every interval and not only at the end. A wrong miss mask or wrong transfer arithmetic shows up in share_vec within the same interval, two edges after the strobe; the share sum drifting away from 256 is the quickest symptom. Clamping faults only appear after long one-sided runs, which are driven until the share reaches its floor and then its ceiling.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_APPLY = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/sdb_run_counter.sv
module sdb_run_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic hit,
    input  logic clr,
    output logic full
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            if (!hit)
                cnt <= '0;
            else if (cnt != CW'(LIMIT))
                cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt == CW'(LIMIT));

endmodule

// File: rtl/sdb_qos_layout.sv
module sdb_qos_layout #(
    parameter int NAPP = 4,
    parameter int SH_W = 8,
    parameter int IW   = 2
) (
    input  logic [IW-1:0]        crit_sel,
    input  logic [SH_W-1:0]      crit_share,
    output logic [NAPP*SH_W-1:0] layout
);
    localparam int TOTAL = 1 << SH_W;
    localparam int AW    = SH_W + 2;

    logic [AW-1:0] rest, each, rem;
    logic          rem_given;

    always_comb begin
        rest      = AW'(TOTAL) - AW'(crit_share);
        each      = rest / AW'(NAPP - 1);
        rem       = rest % AW'(NAPP - 1);
        rem_given = 1'b0;
        layout    = '0;
        for (int i = 0; i < NAPP; i++) begin
            if (IW'(i) == crit_sel) begin
                layout[i*SH_W +: SH_W] = crit_share;
            end else begin
                layout[i*SH_W +: SH_W] = SH_W'(each + (rem_given ? AW'(0) : rem));
                rem_given = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdb_fair_rebal.sv
module sdb_fair_rebal #(
    parameter int NAPP = 4,
    parameter int SH_W = 8,
    parameter int STEP = 8
) (
    input  logic [NAPP*SH_W-1:0] share_in,
    input  logic [NAPP-1:0]      miss_mask,
    output logic [NAPP*SH_W-1:0] share_out
);
    localparam int AW = SH_W + $clog2(NAPP) + 1;

    logic [AW-1:0] give [NAPP];
    logic [AW-1:0] pool, nmiss, divisor, each, rem;
    logic          rem_given;

    always_comb begin
        pool  = '0;
        nmiss = '0;
        for (int i = 0; i < NAPP; i++) begin
            give[i] = '0;
            if (miss_mask[i]) begin
                nmiss = nmiss + 1'b1;
            end else if (AW'(share_in[i*SH_W +: SH_W]) > AW'(STEP)) begin
                give[i] = AW'(STEP);
            end else begin
                give[i] = AW'(share_in[i*SH_W +: SH_W]) - 1'b1;
            end
            pool = pool + give[i];
        end
        divisor   = (nmiss == '0) ? AW'(1) : nmiss;
        each      = pool / divisor;
        rem       = pool % divisor;
        rem_given = 1'b0;
        share_out = share_in;
        if (nmiss != '0 && nmiss != AW'(NAPP)) begin
            for (int i = 0; i < NAPP; i++) begin
                if (miss_mask[i]) begin
                    share_out[i*SH_W +: SH_W] = SH_W'(AW'(share_in[i*SH_W +: SH_W])
                                                + each + (rem_given ? AW'(0) : rem));
                    rem_given = 1'b1;
                end else begin
                    share_out[i*SH_W +: SH_W] = SH_W'(AW'(share_in[i*SH_W +: SH_W]) - give[i]);
                end
            end
        end
    end

endmodule

// File: rtl/sdb_bw_alloc.sv
module sdb_bw_alloc
    import sdb_pkg::*;
#(
    parameter int NAPP       = 4,
    parameter int SD_W       = 12,
    parameter int SH_W       = 8,
    parameter int N_INT      = 4,
    parameter int EPS        = 2,
    parameter int STEP       = 8,
    parameter int INIT_SHARE = 64,
    parameter int BOUND_INIT = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fair_mode,
    input  logic [1:0]           crit_sel,
    input  logic                 sd_valid,
    input  logic [NAPP*SD_W-1:0] sd_vec,
    output logic [NAPP*SH_W-1:0] share_vec,
    output logic [SD_W-1:0]      bound,
    output logic                 notify
);
    localparam int TOTAL = 1 << SH_W;
    localparam int MAXC  = TOTAL - (NAPP - 1);
    localparam int HALF  = NAPP / 2;
    localparam int NW    = $clog2(NAPP + 1);
    localparam int QW    = (N_INT > 1) ? $clog2(N_INT) : 1;

    function automatic logic [NAPP*SH_W-1:0] reset_layout();
        logic [NAPP*SH_W-1:0] v;
        int rest, each, rem;
        rest = TOTAL - INIT_SHARE;
        each = rest / (NAPP - 1);
        rem  = rest % (NAPP - 1);
        v    = '0;
        v[SH_W-1:0] = SH_W'(INIT_SHARE);
        for (int i = 1; i < NAPP; i++)
            v[i*SH_W +: SH_W] = SH_W'(each + ((i == 1) ? rem : 0));
        return v;
    endfunction

    localparam logic [NAPP*SH_W-1:0] RST_SHARES = reset_layout();

    ctl_state_t                   state, state_nx;
    logic [NAPP-1:0][SD_W-1:0]    sd_q;
    logic [NAPP*SH_W-1:0]         share_q, qos_shares, fair_shares;
    logic [SH_W-1:0]              crit_share, c_next, c_up, c_dn;
    logic [SH_W:0]                c_sum;
    logic [SD_W-1:0]              bound_q, max_sd, crit_sd;
    logic [SD_W:0]                band_hi, crit_plus;
    logic [NAPP-1:0]              miss_mask;
    logic [NW-1:0]                nmiss;
    logic                         notify_q, crit_miss, crit_hi, crit_lo;
    logic                         majority, all_met, review_q;
    logic [QW-1:0]                qcnt;
    logic                         note_full, tight_full, relax_full;
    logic                         in_eval, apply_phase;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (sd_valid) state_nx = ST_EVAL;
            ST_EVAL:  state_nx = ST_APPLY;
            ST_APPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign in_eval     = (state == ST_EVAL);
    assign apply_phase = (state == ST_APPLY);

    // interval classification
    always_comb begin
        nmiss  = '0;
        max_sd = '0;
        for (int i = 0; i < NAPP; i++) begin
            miss_mask[i] = sd_q[i] > bound_q;
            nmiss        = nmiss + NW'(miss_mask[i]);
            if (sd_q[i] > max_sd) max_sd = sd_q[i];
        end
        crit_sd   = sd_q[crit_sel];
        crit_miss = crit_sd > bound_q;
        band_hi   = {1'b0, bound_q} + (SD_W+1)'(EPS);
        crit_plus = {1'b0, crit_sd} + (SD_W+1)'(EPS);
        crit_hi   = {1'b0, crit_sd} > band_hi;
        crit_lo   = crit_plus < {1'b0, bound_q};
        majority  = nmiss > NW'(HALF);
        all_met   = (nmiss == '0);
    end

    // critical share step with clamping
    always_comb begin
        c_sum  = {1'b0, crit_share} + (SH_W+1)'(STEP);
        c_up   = (c_sum > (SH_W+1)'(MAXC)) ? SH_W'(MAXC) : c_sum[SH_W-1:0];
        c_dn   = (crit_share > SH_W'(STEP)) ? crit_share - SH_W'(STEP) : SH_W'(1);
        c_next = crit_hi ? c_up : (crit_lo ? c_dn : crit_share);
    end

    sdb_qos_layout #(.NAPP(NAPP), .SH_W(SH_W), .IW(2)) u_layout (
        .crit_sel   (crit_sel),
        .crit_share (c_next),
        .layout     (qos_shares)
    );

    sdb_fair_rebal #(.NAPP(NAPP), .SH_W(SH_W), .STEP(STEP)) u_rebal (
        .share_in  (share_q),
        .miss_mask (miss_mask),
        .share_out (fair_shares)
    );

    sdb_run_counter #(.LIMIT(N_INT)) u_note (
        .clk (clk), .rst_n (rst_n),
        .step (in_eval),
        .hit  (fair_mode ? majority : crit_miss),
        .clr  (1'b0),
        .full (note_full)
    );

    sdb_run_counter #(.LIMIT(N_INT)) u_tight (
        .clk (clk), .rst_n (rst_n),
        .step (in_eval && fair_mode),
        .hit  (all_met),
        .clr  (apply_phase && fair_mode && tight_full),
        .full (tight_full)
    );

    sdb_run_counter #(.LIMIT(N_INT)) u_relax (
        .clk (clk), .rst_n (rst_n),
        .step (in_eval && fair_mode),
        .hit  (majority),
        .clr  (apply_phase && fair_mode && relax_full),
        .full (relax_full)
    );

    // per-state datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q       <= '0;
            share_q    <= RST_SHARES;
            crit_share <= SH_W'(INIT_SHARE);
            bound_q    <= SD_W'(BOUND_INIT);
            notify_q   <= 1'b0;
            qcnt       <= '0;
            review_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (sd_valid) sd_q <= sd_vec;
                end
                ST_EVAL: begin
                    if (fair_mode) begin
                        review_q <= 1'b0;
                    end else begin
                        review_q <= (qcnt == QW'(N_INT - 1));
                        qcnt     <= (qcnt == QW'(N_INT - 1)) ? '0 : qcnt + 1'b1;
                    end
                end
                ST_APPLY: begin
                    notify_q <= note_full;
                    if (fair_mode) begin
                        share_q <= fair_shares;
                        if (tight_full)
                            bound_q <= (max_sd == '1) ? max_sd : max_sd + 1'b1;
                        else if (relax_full)
                            bound_q <= max_sd;
                    end else if (review_q) begin
                        crit_share <= c_next;
                        share_q    <= qos_shares;
                    end
                end
                default: ;
            endcase
        end
    end

    assign share_vec = share_q;
    assign bound     = bound_q;
    assign notify    = notify_q;

endmodule

// File: rtl/sdb_bw_alloc_chk.sv
module sdb_bw_alloc_chk #(
    parameter int NAPP = 4,
    parameter int SH_W = 8,
    parameter int SD_W = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fair_mode,
    input logic                 apply_phase,
    input logic [NAPP*SH_W-1:0] share_vec,
    input logic [SD_W-1:0]      bound,
    input logic                 notify
);
    localparam int TOTAL = 1 << SH_W;

    logic [SH_W+3:0] total;
    logic            any_zero;

    always_comb begin
        total    = '0;
        any_zero = 1'b0;
        for (int i = 0; i < NAPP; i++) begin
            total = total + (SH_W+4)'(share_vec[i*SH_W +: SH_W]);
            if (share_vec[i*SH_W +: SH_W] == '0) any_zero = 1'b1;
        end
    end

    a_r12_sum_kept: assert property (@(posedge clk) disable iff (!rst_n)
        total == (SH_W+4)'(TOTAL));

    a_r12_r8_no_empty_share: assert property (@(posedge clk) disable iff (!rst_n)
        !any_zero);

    a_r11_shares_move_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_phase |=> $stable(share_vec));

    a_r6_notify_moves_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_phase |=> $stable(notify));

    a_r11_bound_fixed_in_qos: assert property (@(posedge clk) disable iff (!rst_n)
        !fair_mode |=> $stable(bound));

endmodule

bind sdb_bw_alloc sdb_bw_alloc_chk #(.NAPP(NAPP), .SH_W(SH_W), .SD_W(SD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fair_mode   (fair_mode),
    .apply_phase (apply_phase),
    .share_vec   (share_vec),
    .bound       (bound),
    .notify      (notify)
);

// File: tb/sim_sdb_bw_alloc.sv
module sim_sdb_bw_alloc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fair_mode = 1'b0;
    logic [1:0]  crit_sel = 2'd0;
    logic        sd_valid = 1'b0;
    logic [47:0] sd_vec = '0;
    logic [31:0] share_vec;
    logic [11:0] bound;
    logic        notify;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sdb_bw_alloc u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .fair_mode (fair_mode),
        .crit_sel  (crit_sel),
        .sd_valid  (sd_valid),
        .sd_vec    (sd_vec),
        .share_vec (share_vec),
        .bound     (bound),
        .notify    (notify)
    );

    typedef struct packed {
        logic        fair;
        logic [1:0]  crit;
        logic [11:0] s0, s1, s2, s3;
        logic [7:0]  e0, e1, e2, e3;
        logic [11:0] eb;
        logic        en;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 2'd0, 12'd60, 12'd16, 12'd16, 12'd16, 8'd64, 8'd64, 8'd64, 8'd64, 12'd48, 1'b0}, // R2 no review yet
        '{1'b0, 2'd0, 12'd60, 12'd16, 12'd16, 12'd16, 8'd64, 8'd64, 8'd64, 8'd64, 12'd48, 1'b0},
        '{1'b0, 2'd0, 12'd60, 12'd16, 12'd16, 12'd16, 8'd64, 8'd64, 8'd64, 8'd64, 12'd48, 1'b0},
        '{1'b0, 2'd0, 12'd60, 12'd16, 12'd16, 12'd16, 8'd72, 8'd62, 8'd61, 8'd61, 12'd48, 1'b1}, // R2 R4 R6 raise
        '{1'b0, 2'd0, 12'd49, 12'd16, 12'd16, 12'd16, 8'd72, 8'd62, 8'd61, 8'd61, 12'd48, 1'b1}, // R6 still missing
        '{1'b0, 2'd0, 12'd40, 12'd16, 12'd16, 12'd16, 8'd72, 8'd62, 8'd61, 8'd61, 12'd48, 1'b0}, // R6 drops
        '{1'b0, 2'd0, 12'd47, 12'd16, 12'd16, 12'd16, 8'd72, 8'd62, 8'd61, 8'd61, 12'd48, 1'b0},
        '{1'b0, 2'd0, 12'd47, 12'd16, 12'd16, 12'd16, 8'd72, 8'd62, 8'd61, 8'd61, 12'd48, 1'b0}, // R3 hold in band
        '{1'b0, 2'd0, 12'd20, 12'd16, 12'd16, 12'd16, 8'd72, 8'd62, 8'd61, 8'd61, 12'd48, 1'b0},
        '{1'b0, 2'd0, 12'd20, 12'd16, 12'd16, 12'd16, 8'd72, 8'd62, 8'd61, 8'd61, 12'd48, 1'b0},
        '{1'b0, 2'd0, 12'd20, 12'd16, 12'd16, 12'd16, 8'd72, 8'd62, 8'd61, 8'd61, 12'd48, 1'b0},
        '{1'b0, 2'd0, 12'd20, 12'd16, 12'd16, 12'd16, 8'd64, 8'd64, 8'd64, 8'd64, 12'd48, 1'b0}, // R3 lower
        '{1'b0, 2'd1, 12'd16, 12'd60, 12'd16, 12'd16, 8'd64, 8'd64, 8'd64, 8'd64, 12'd48, 1'b0},
        '{1'b0, 2'd1, 12'd16, 12'd60, 12'd16, 12'd16, 8'd64, 8'd64, 8'd64, 8'd64, 12'd48, 1'b0},
        '{1'b0, 2'd1, 12'd16, 12'd60, 12'd16, 12'd16, 8'd64, 8'd64, 8'd64, 8'd64, 12'd48, 1'b0},
        '{1'b0, 2'd1, 12'd16, 12'd60, 12'd16, 12'd16, 8'd62, 8'd72, 8'd61, 8'd61, 12'd48, 1'b1}, // R4 remainder to app0
        '{1'b1, 2'd0, 12'd60, 12'd60, 12'd60, 12'd10, 8'd66, 8'd74, 8'd63, 8'd53, 12'd48, 1'b1}, // R7 remainder to app0
        '{1'b1, 2'd0, 12'd60, 12'd60, 12'd60, 12'd10, 8'd70, 8'd76, 8'd65, 8'd45, 12'd48, 1'b1},
        '{1'b1, 2'd0, 12'd60, 12'd60, 12'd60, 12'd10, 8'd74, 8'd78, 8'd67, 8'd37, 12'd48, 1'b1},
        '{1'b1, 2'd0, 12'd60, 12'd60, 12'd60, 12'd10, 8'd78, 8'd80, 8'd69, 8'd29, 12'd60, 1'b1}, // R10 relax
        '{1'b1, 2'd0, 12'd60, 12'd60, 12'd60, 12'd10, 8'd78, 8'd80, 8'd69, 8'd29, 12'd60, 1'b0}, // R8 all met
        '{1'b1, 2'd0, 12'd60, 12'd60, 12'd60, 12'd10, 8'd78, 8'd80, 8'd69, 8'd29, 12'd60, 1'b0},
        '{1'b1, 2'd0, 12'd60, 12'd60, 12'd60, 12'd10, 8'd78, 8'd80, 8'd69, 8'd29, 12'd60, 1'b0},
        '{1'b1, 2'd0, 12'd60, 12'd60, 12'd60, 12'd10, 8'd78, 8'd80, 8'd69, 8'd29, 12'd61, 1'b0}, // R9 tighten
        '{1'b1, 2'd0, 12'd61, 12'd62, 12'd10, 12'd10, 8'd70, 8'd104, 8'd61, 8'd21, 12'd61, 1'b0}, // R7 single taker
        '{1'b1, 2'd0, 12'd10, 12'd62, 12'd10, 12'd10, 8'd62, 8'd128, 8'd53, 8'd13, 12'd61, 1'b0},
        '{1'b1, 2'd0, 12'd10, 12'd62, 12'd10, 12'd10, 8'd54, 8'd152, 8'd45, 8'd5, 12'd61, 1'b0},
        '{1'b1, 2'd0, 12'd10, 12'd62, 12'd10, 12'd10, 8'd46, 8'd172, 8'd37, 8'd1, 12'd61, 1'b0}, // R8 partial give
        '{1'b1, 2'd0, 12'd10, 12'd62, 12'd10, 12'd10, 8'd38, 8'd188, 8'd29, 8'd1, 12'd61, 1'b0}, // R8 floor held
        '{1'b1, 2'd0, 12'd100, 12'd100, 12'd100, 12'd100, 8'd38, 8'd188, 8'd29, 8'd1, 12'd61, 1'b0} // R8 all miss
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic fm, input logic [1:0] cs, input logic [47:0] sv);
        @(negedge clk);
        fair_mode = fm;
        crit_sel  = cs;
        sd_vec    = sv;
        sd_valid  = 1'b1;
        @(negedge clk);
        sd_valid  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(share_vec == {4{8'd64}}, "R1", "reset shares", share_vec, {4{8'd64}});
        chk(bound == 12'd48, "R1", "reset bound", 32'(bound), 32'd48);
        chk(notify == 1'b0, "R1", "reset notify", 32'(notify), 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            send(TBL[k].fair, TBL[k].crit, {TBL[k].s3, TBL[k].s2, TBL[k].s1, TBL[k].s0});
            chk(share_vec == {TBL[k].e3, TBL[k].e2, TBL[k].e1, TBL[k].e0},
                TBL[k].fair ? "R7/R8" : "R2/R3/R4", $sformatf("row %0d shares", k),
                share_vec, {TBL[k].e3, TBL[k].e2, TBL[k].e1, TBL[k].e0});
            chk(bound == TBL[k].eb, TBL[k].fair ? "R9/R10" : "R11",
                $sformatf("row %0d bound", k), 32'(bound), 32'(TBL[k].eb));
            chk(notify == TBL[k].en, "R6", $sformatf("row %0d notify", k),
                32'(notify), 32'(TBL[k].en));
        end

        // R5 floor: critical app3 well under bound for 9 reviews
        do_reset();
        for (int k = 0; k < 36; k++) send(1'b0, 2'd3, {12'd10, 12'd16, 12'd16, 12'd16});
        chk(share_vec == {8'd1, 8'd85, 8'd85, 8'd85}, "R5", "floor shares",
            share_vec, {8'd1, 8'd85, 8'd85, 8'd85});
        chk(notify == 1'b0, "R6", "floor notify", 32'(notify), 32'd0);

        // R5 ceiling: critical app3 far over bound for 33 reviews
        for (int k = 0; k < 132; k++) send(1'b0, 2'd3, {12'd100, 12'd16, 12'd16, 12'd16});
        chk(share_vec == {8'd253, 8'd1, 8'd1, 8'd1}, "R5", "ceiling shares",
            share_vec, {8'd253, 8'd1, 8'd1, 8'd1});
        chk(notify == 1'b1, "R6", "ceiling notify", 32'(notify), 32'd1);
        chk(bound == 12'd48, "R11", "qos bound unchanged", 32'(bound), 32'd48);

        // R11 strobe while busy is ignored
        do_reset();
        @(negedge clk);
        fair_mode = 1'b1;
        crit_sel  = 2'd0;
        sd_vec    = {12'd10, 12'd10, 12'd10, 12'd100};
        sd_valid  = 1'b1;
        @(negedge clk);
        sd_vec    = {12'd10, 12'd10, 12'd100, 12'd10};
        @(negedge clk);
        sd_valid  = 1'b0;
        repeat (4) @(negedge clk);
        chk(share_vec == {8'd56, 8'd56, 8'd56, 8'd88}, "R11", "busy strobe dropped",
            share_vec, {8'd56, 8'd56, 8'd56, 8'd88});
        // R12 sum after the busy case
        chk((32'(share_vec[7:0]) + 32'(share_vec[15:8]) + 32'(share_vec[23:16])
             + 32'(share_vec[31:24])) == 32'd256, "R12", "share sum",
            32'(share_vec[7:0]) + 32'(share_vec[15:8]) + 32'(share_vec[23:16])
             + 32'(share_vec[31:24]), 32'd256);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule